// File: doc/BRIEF.md
# CAN Bit Timing and Arbitration Engine

This block sits between a frame sequencer that works one bit at a time and the TX/RX pins of a CAN transceiver. It divides the system clock into time quanta and builds each bit from a programmable number of quanta. It samples the bus at a programmable quantum late in the bit. It keeps its bit grid aligned with other nodes by adding or dropping one quantum when a recessive-to-dominant edge arrives late or early.

The bus is a wired-AND. Dominant is logic 0 and recessive is logic 1, and an undriven bus reads 1. While the node transmits, every recessive bit it drives is compared with the value sampled from the bus. If the bus reads dominant instead, the node has lost arbitration. It then releases the bus until the sequencer drops transmit-enable.

The sequencer presents the next bit on `tx_bit` when it sees `bit_stb`. It reads received bits from `rx_bit` after each `samp_stb`. Frame layout, CRC and stuffing are handled elsewhere.

Top module: `can_bit_engine`

## Requirements
- R1: After reset, `tx_pin`=1, `rx_bit`=1, `arb_lost`=0, and `samp_stb` and `bit_stb` are both 0.
- R2: One quantum lasts `tq_div`+1 clock cycles. With no correction, a bit lasts `bit_tq` quanta, so `bit_stb` pulses for one cycle every (`tq_div`+1)·`bit_tq` cycles. `bit_tq` ranges from 9 to 20.
- R3: `samp_stb` pulses (`tq_div`+1)·(`samp_tq`+1) cycles after `bit_stb`, at the end of quantum index `samp_tq` (the first quantum has index 0). `samp_tq` lies between 2 and `bit_tq`-3. `samp_stb` and `bit_stb` are never high in the same cycle.
- R4: `rx_pin` passes through a two-flop synchroniser. `rx_bit` takes the synchronised bus value in the cycle after `samp_stb` and changes at no other time.
- R5: A falling bus edge detected in quantum index 1 to `samp_tq`-1 lengthens the current bit by one quantum.
- R6: A falling edge detected in a quantum index above `samp_tq` shortens the current bit by one quantum.
- R7: A falling edge detected inside quantum index `samp_tq` or quantum index 0 leaves the bit length unchanged. At most one quantum of correction is applied per bit.
- R8: A falling edge is ignored while `rx_bit` is 0 (the last sampled bit was dominant).
- R9: `tx_bit` is latched in the cycle of `bit_stb`. From the next cycle, `tx_pin` carries the latched bit while `tx_en`=1 and `arb_lost`=0, and is 1 otherwise.
- R10: If the latched bit is 1, `tx_en`=1, and the bus samples 0 at `samp_stb`, then `arb_lost` rises in the next cycle and `tx_pin` is held at 1.
- R11: Driving a 0 while the other nodes leave the bus recessive never sets `arb_lost`.
- R12: `arb_lost` stays set while `tx_en`=1 and clears in the cycle after `tx_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tq_div | input | DIV_W | System cycles per quantum minus one |
| bit_tq | input | TQ_W | Quanta per nominal bit (9 to 20) |
| samp_tq | input | TQ_W | Quantum index of the sample point |
| tx_bit | input | 1 | Next bit from the frame sequencer |
| tx_en | input | 1 | Node is transmitting |
| rx_pin | input | 1 | Receive pin of the transceiver |
| tx_pin | output | 1 | Transmit pin of the transceiver |
| rx_bit | output | 1 | Last sampled bus value |
| samp_stb | output | 1 | One-cycle pulse at the sample point |
| bit_stb | output | 1 | One-cycle pulse at each bit boundary |
| arb_lost | output | 1 | Arbitration lost, transmitter released |

## Verification
Each result has its own delay:
- `samp_stb` is due (`tq_div`+1)·(`samp_tq`+1) cycles after a `bit_stb`.
- The next `bit_stb` is due (`tq_div`+1) times the corrected quantum count after the previous one.
- `rx_bit` and `arb_lost` change one cycle after `samp_stb`.
- `tx_pin` follows one cycle after `bit_stb`.

The bench counts falling clock edges from each `bit_stb` and compares strobe positions against these products. It places each bus edge so that, allowing for the two synchroniser cycles, the edge is detected in the middle of the intended quantum. Level checks are read on the falling edge that follows the register update.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    ADJ_NONE  = 2'd0,
    ADJ_LONG  = 2'd1,
    ADJ_SHORT = 2'd2
  } adj_e;
endpackage

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] tq_div,
  output logic             tq_tick
);
  logic [DIV_W-1:0] cnt;

  assign tq_tick = (cnt >= tq_div);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (tq_tick) cnt <= '0;
    else              cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/cbt_rx_sync.sv
module cbt_rx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_pin,
  input  logic samp_stb,
  output logic rx_s,
  output logic rx_fall,
  output logic rx_bit
);
  logic s1, s2, s3;

  assign rx_s    = s2;
  assign rx_fall = s3 & ~s2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1     <= 1'b1;
      s2     <= 1'b1;
      s3     <= 1'b1;
      rx_bit <= 1'b1;
    end else begin
      s1 <= rx_pin;
      s2 <= s1;
      s3 <= s2;
      if (samp_stb) rx_bit <= s2;
    end
  end
endmodule

// File: rtl/cbt_phase.sv
module cbt_phase
  import can_bt_pkg::*;
#(
  parameter int TQ_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tq_tick,
  input  logic [TQ_W-1:0] bit_tq,
  input  logic [TQ_W-1:0] samp_tq,
  input  logic            edge_in,
  output logic [TQ_W-1:0] q_idx,
  output adj_e            adj_now,
  output logic            samp_stb,
  output logic            bit_stb
);
  // Which correction an edge seen in quantum q asks for
  function automatic adj_e classify(input logic [TQ_W-1:0] q,
                                    input logic [TQ_W-1:0] sp);
    if (q == '0 || q == sp) return ADJ_NONE;
    else if (q < sp)        return ADJ_LONG;
    else                    return ADJ_SHORT;
  endfunction

  // Index of the last quantum of the current bit
  function automatic logic [TQ_W-1:0] last_idx(input logic [TQ_W-1:0] n,
                                               input adj_e a);
    case (a)
      ADJ_LONG:  return n;
      ADJ_SHORT: return n - TQ_W'(2);
      default:   return n - TQ_W'(1);
    endcase
  endfunction

  logic [TQ_W-1:0] q;
  adj_e            adj;
  logic            pend;
  logic            edge_now;
  logic            wrap;

  assign edge_now = pend | edge_in;
  assign adj_now  = (adj != ADJ_NONE) ? adj :
                    (edge_now ? classify(q, samp_tq) : ADJ_NONE);
  assign wrap     = (q >= last_idx(bit_tq, adj_now));
  assign samp_stb = tq_tick && (q == samp_tq);
  assign bit_stb  = tq_tick && wrap;
  assign q_idx    = q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q    <= '0;
      adj  <= ADJ_NONE;
      pend <= 1'b0;
    end else if (tq_tick) begin
      pend <= 1'b0;
      if (wrap) begin
        q   <= '0;
        adj <= ADJ_NONE;
      end else begin
        q   <= q + TQ_W'(1);
        adj <= adj_now;
      end
    end else begin
      pend <= pend | edge_in;
    end
  end
endmodule

// File: rtl/cbt_arbiter.sv
module cbt_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic samp_stb,
  input  logic tx_bit,
  input  logic tx_en,
  input  logic rx_s,
  output logic tx_pin,
  output logic arb_lost
);
  logic cur_tx;

  assign tx_pin = (tx_en && !arb_lost) ? cur_tx : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_tx   <= 1'b1;
      arb_lost <= 1'b0;
    end else begin
      if (bit_stb) cur_tx <= tx_bit;
      if (!tx_en)
        arb_lost <= 1'b0;
      else if (samp_stb && !arb_lost && cur_tx && !rx_s)
        arb_lost <= 1'b1;
    end
  end
endmodule

// File: rtl/can_bit_engine.sv
module can_bit_engine
  import can_bt_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int TQ_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] tq_div,
  input  logic [TQ_W-1:0]  bit_tq,
  input  logic [TQ_W-1:0]  samp_tq,
  input  logic             tx_bit,
  input  logic             tx_en,
  input  logic             rx_pin,
  output logic             tx_pin,
  output logic             rx_bit,
  output logic             samp_stb,
  output logic             bit_stb,
  output logic             arb_lost
);
  logic            tq_tick;
  logic            rx_s;
  logic            rx_fall;
  logic            edge_ok;
  logic [TQ_W-1:0] q_idx;
  adj_e            adj_now;

  // only an edge after a recessive sample can resynchronise
  assign edge_ok = rx_fall & rx_bit;

  cbt_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tq_div(tq_div), .tq_tick(tq_tick)
  );

  cbt_rx_sync u_rx (
    .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .samp_stb(samp_stb),
    .rx_s(rx_s), .rx_fall(rx_fall), .rx_bit(rx_bit)
  );

  cbt_phase #(.TQ_W(TQ_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .tq_tick(tq_tick), .bit_tq(bit_tq),
    .samp_tq(samp_tq), .edge_in(edge_ok), .q_idx(q_idx),
    .adj_now(adj_now), .samp_stb(samp_stb), .bit_stb(bit_stb)
  );

  cbt_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .samp_stb(samp_stb),
    .tx_bit(tx_bit), .tx_en(tx_en), .rx_s(rx_s),
    .tx_pin(tx_pin), .arb_lost(arb_lost)
  );
endmodule

// File: rtl/cbt_checker.sv
module cbt_checker
  import can_bt_pkg::*;
#(
  parameter int TQ_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tx_en,
  input logic            tx_pin,
  input logic            rx_bit,
  input logic            samp_stb,
  input logic            bit_stb,
  input logic            arb_lost,
  input logic [TQ_W-1:0] q_idx,
  input adj_e            adj_now
);
  assert_strobes_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(samp_stb && bit_stb));

  assert_new_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> (q_idx == '0));

  assert_rx_on_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_bit) |-> $past(samp_stb));

  assert_tx_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> tx_pin);

  assert_lost_at_sample_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> ($past(samp_stb) && !rx_bit));

  assert_lost_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && tx_en) |=> arb_lost);

  assert_lost_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !arb_lost);

  assert_one_fix_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_now != ADJ_NONE && !bit_stb) |=> (adj_now == $past(adj_now)));
endmodule

bind can_bit_engine cbt_checker #(.TQ_W(TQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_pin(tx_pin),
  .rx_bit(rx_bit), .samp_stb(samp_stb), .bit_stb(bit_stb),
  .arb_lost(arb_lost), .q_idx(q_idx), .adj_now(adj_now)
);

// File: tb/can_bit_engine_test.sv
module can_bit_engine_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tq_div = 8'd0;
  logic [4:0] bit_tq = 5'd10;
  logic [4:0] samp_tq = 5'd6;
  logic       tx_bit = 1'b1;
  logic       tx_en = 1'b0;
  logic       other = 1'b1;
  logic       rx_pin;
  logic       tx_pin, rx_bit, samp_stb, bit_stb, arb_lost;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  // wired-AND bus: this node and one other node
  assign rx_pin = tx_pin & other;

  always #5 clk = ~clk;

  can_bit_engine uut (
    .clk(clk), .rst_n(rst_n), .tq_div(tq_div), .bit_tq(bit_tq),
    .samp_tq(samp_tq), .tx_bit(tx_bit), .tx_en(tx_en), .rx_pin(rx_pin),
    .tx_pin(tx_pin), .rx_bit(rx_bit), .samp_stb(samp_stb),
    .bit_stb(bit_stb), .arb_lost(arb_lost)
  );

  // {tq_div, bit_tq, samp_tq}
  localparam int CFG [4][3] = '{
    '{0, 9, 5}, '{1, 10, 6}, '{3, 16, 10}, '{4, 20, 13}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_bit();
    do @(negedge clk); while (!bit_stb);
  endtask

  // Start at a bit_stb negedge; count cycles to the next one
  task automatic measure(input int drop_at, input int rise_at,
                         output int len, output int samp_at);
    int n;
    n = 0;
    samp_at = -1;
    forever begin
      @(negedge clk);
      n++;
      if (n == drop_at) other = 1'b0;
      if (n == rise_at) other = 1'b1;
      if (samp_stb) samp_at = n;
      if (bit_stb) break;
    end
    len = n;
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int len, sp;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(tx_pin == 1'b1, "R1 tx_pin", tx_pin, 1);
    check(rx_bit == 1'b1, "R1 rx_bit", rx_bit, 1);
    check(arb_lost == 1'b0, "R1 arb_lost", arb_lost, 0);
    check(samp_stb == 1'b0, "R1 samp_stb", samp_stb, 0);
    check(bit_stb == 1'b0, "R1 bit_stb", bit_stb, 0);
    rst_n = 1'b1;

    // R2/R3 vector table
    for (int i = 0; i < 4; i++) begin
      wait_bit();
      tq_div  = 8'(CFG[i][0]);
      bit_tq  = 5'(CFG[i][1]);
      samp_tq = 5'(CFG[i][2]);
      wait_bit();
      wait_bit();
      measure(-1, -1, len, sp);
      check(len == (CFG[i][0] + 1) * CFG[i][1], "R2 bit period", len,
            (CFG[i][0] + 1) * CFG[i][1]);
      check(sp == (CFG[i][0] + 1) * (CFG[i][2] + 1), "R3 sample offset", sp,
            (CFG[i][0] + 1) * (CFG[i][2] + 1));
    end

    // resynchronisation: 8 cycles per quantum, 12 quanta, sample at 7
    wait_bit();
    tq_div = 8'd7; bit_tq = 5'd12; samp_tq = 5'd7;
    wait_bit(); wait_bit(); wait_bit();
    check(rx_bit == 1'b1, "R4 idle sample", rx_bit, 1);
    measure(20, -1, len, sp);            // edge detected in quantum 2
    check(len == 104, "R5 late edge", len, 104);
    check(rx_bit == 1'b0, "R4 dominant sample", rx_bit, 0);
    measure(20, 4, len, sp);             // edge after a dominant sample
    check(len == 96, "R8 edge after dominant", len, 96);
    other = 1'b1;
    wait_bit(); wait_bit();
    measure(58, -1, len, sp);            // edge detected in quantum 7
    check(len == 96, "R7 edge in sample quantum", len, 96);
    other = 1'b1;
    wait_bit(); wait_bit();
    measure(74, -1, len, sp);            // edge detected in quantum 9
    check(len == 88, "R6 early edge", len, 88);
    other = 1'b1;
    wait_bit(); wait_bit();

    // R10 arbitration lost
    tx_bit = 1'b1;
    tx_en  = 1'b1;
    wait_bit();
    other = 1'b0;
    do @(negedge clk); while (!samp_stb);
    check(arb_lost == 1'b0, "R10 before sample", arb_lost, 0);
    @(negedge clk);
    check(arb_lost == 1'b1, "R10 lost after sample", arb_lost, 1);
    check(tx_pin == 1'b1, "R10 released", tx_pin, 1);
    tx_bit = 1'b0;
    wait_bit();
    @(negedge clk);
    check(tx_pin == 1'b1, "R10 held recessive", tx_pin, 1);
    check(arb_lost == 1'b1, "R12 sticky", arb_lost, 1);
    tx_en = 1'b0;
    @(negedge clk);
    check(arb_lost == 1'b0, "R12 cleared", arb_lost, 0);

    // R9/R11 dominant against recessive
    other = 1'b1;
    tx_en = 1'b1;
    tx_bit = 1'b0;
    wait_bit();
    @(negedge clk);
    check(tx_pin == 1'b0, "R9 drives latched bit", tx_pin, 0);
    do @(negedge clk); while (!samp_stb);
    @(negedge clk);
    check(arb_lost == 1'b0, "R11 no loss", arb_lost, 0);
    check(rx_bit == 1'b0, "R11 bus dominant", rx_bit, 0);
    tx_bit = 1'b1;
    wait_bit();
    @(negedge clk);
    check(tx_pin == 1'b1, "R9 next bit", tx_pin, 1);
    tx_en = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule